// File: doc/BRIEF.md
# Flash Completion Poller

This controller runs on the host side of a flash memory. It decides when an embedded program or erase operation inside the device has finished, and whether it finished cleanly. The host gives it a one-cycle start strobe and the address of the location being programmed or erased. The controller then reads the device status word from that address again and again, through a simple read port that carries one word per request and acknowledge. Each read stays pending until the memory side acknowledges it. After each pair of reads it follows a fixed decision flow. It ends by pulsing a completion flag for one cycle, together with either a pass flag or a fail flag.

The controller groups the reads in pairs. While the operation is still running, the toggle bit (bit 6) changes value on every read, so the two reads of a pair disagree. When the operation ends, the toggle bit holds steady. The error bit (bit 5) reports that the device's internal time limit has expired. The toggle bit can stop changing at the same moment the error bit rises. So when the error bit is seen, the controller takes one more confirming pair before it declares failure.

An optional limit on the number of pairs stops a device that keeps toggling and never raises its error bit.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After a synchronous reset, `done_o`, `pass_o`, `fail_o` and `rd_req_o` are all low and the controller is idle.
- R2: An accepted start makes the controller issue status reads in consecutive pairs, all at the start address. Each read holds `rd_req_o` high, with a stable address, until `rd_ack_i` is sampled high. At most one read is pending at any time.
- R3: When bit 6 of the two reads of a pair is equal, the result is pass.
- R4: When bit 6 differs between the two reads and bit 5 of the second (most recent) read is 0, a new pair is read. Bit 5 of the first read of the pair has no effect.
- R5: When bit 6 differs and bit 5 of the second read is 1, exactly one confirming pair follows. If bit 6 still differs in that pair, the result is fail; otherwise it is pass. The value of bit 5 inside the confirming pair does not matter.
- R6: `done_o` is high for exactly one cycle per operation, with exactly one of `pass_o` and `fail_o` high in that cycle. `pass_o` and `fail_o` are low at all other times. The controller is then idle and issues no further reads.
- R7: A start strobe while an operation is in progress has no effect: the read address, the number of reads and the result of the running operation are unchanged.
- R8: With the limit enabled, the MAX_PAIRS-th consecutive pair that toggles with bit 5 clear gives fail. If that pair has bit 5 set, the confirming pair is taken instead.
- R9: A start strobe in the cycle where `done_o` is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| addr_i | input | ADDR_W | Target address, captured with the start strobe |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | DATA_W | Status word returned by the read |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Pass verdict, valid with done_o |
| fail_o | output | 1 | Fail verdict, valid with done_o |

## Verification
Two functions can fall in the same cycle.

The first is the end of one operation and the start of the next. The bench sees `done_o` and raises `start_i` at once, so the new start is sampled in the completion cycle. It then checks two things: the new operation runs its full read sequence at the new address, and the first result was reported on its own.

The second is the pair-limit fail and the error-bit confirm, which can be due on the same pair. The bench sets bit 5 on exactly the pair that reaches the limit. It expects the confirming pair to be read, and the verdict to come from that pair rather than from the limit.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } tpc_state_e;

  typedef enum logic [1:0] {
    VD_PASS    = 2'd0,
    VD_FAIL    = 2'd1,
    VD_RETRY   = 2'd2,
    VD_CONFIRM = 2'd3
  } tpc_verdict_e;

endpackage

// File: rtl/tpc_reader.sv
`timescale 1ns/1ps
module tpc_reader #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              tog_o,
  output logic              err_o,
  output logic              vld_o
);

  logic unused_data;
  assign unused_data = ^rd_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      tog_o     <= 1'b0;
      err_o     <= 1'b0;
      vld_o     <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (rd_req_o && rd_ack_i) begin
        rd_req_o <= 1'b0;
        tog_o    <= rd_data_i[TOG_BIT];
        err_o    <= rd_data_i[ERR_BIT];
        vld_o    <= 1'b1;
      end else if (go_i && !rd_req_o) begin
        rd_req_o  <= 1'b1;
        rd_addr_o <= addr_i;
      end
    end
  end

  // A pending read keeps its request and address until acknowledged.
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // Data is only reported for a read that was actually acknowledged.
  assert_vld_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (!rd_req_o && $past(rd_ack_i)));

endmodule

// File: rtl/tpc_judge.sv
`timescale 1ns/1ps
module tpc_judge
  import tpc_pkg::*;
(
  input  logic         tog_a_i,
  input  logic         tog_b_i,
  input  logic         err_b_i,
  input  logic         confirm_i,
  input  logic         limit_last_i,
  output tpc_verdict_e verdict_o
);

  logic toggled;
  assign toggled = tog_a_i ^ tog_b_i;

  always_comb begin
    if (!toggled)          verdict_o = VD_PASS;
    else if (confirm_i)    verdict_o = VD_FAIL;
    else if (err_b_i)      verdict_o = VD_CONFIRM;
    else if (limit_last_i) verdict_o = VD_FAIL;
    else                   verdict_o = VD_RETRY;
  end

endmodule

// File: rtl/tpc_pair_limit.sv
`timescale 1ns/1ps
module tpc_pair_limit #(
  parameter int MAX_PAIRS = 1024,
  parameter bit LIMIT_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic bump_i,
  output logic last_o
);

  localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

  generate
    if (LIMIT_EN) begin : g_limit
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || clear_i)           cnt <= '0;
        else if (bump_i && !last_o)   cnt <= cnt + 1'b1;
      end

      assign last_o = (cnt == LAST);

      // No retry is granted once the last permitted pair has been used.
      assert_no_bump_at_last_R8: assert property (@(posedge clk) disable iff (rst)
        (last_o && !clear_i) |=> (cnt == LAST || $past(clear_i)));
    end else begin : g_nolimit
      logic unused_in;
      assign unused_in = clear_i ^ bump_i ^ clk ^ rst;
      assign last_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/toggle_poll_ctrl.sv
`timescale 1ns/1ps
module toggle_poll_ctrl
  import tpc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int TOG_BIT   = 6,
  parameter int ERR_BIT   = 5,
  parameter bit LIMIT_EN  = 1'b1,
  parameter int MAX_PAIRS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);

  tpc_state_e   state;
  tpc_verdict_e verdict;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] go_addr;
  logic confirm_q;
  logic tog_a_q;
  logic s_tog, s_err, s_vld;
  logic go, accept, bump, limit_last, pair_end;

  assign accept   = (state == ST_IDLE) && start_i;
  assign pair_end = (state == ST_SECOND) && s_vld;
  assign bump     = pair_end && (verdict == VD_RETRY);
  assign go_addr  = (state == ST_IDLE) ? addr_i : addr_q;
  assign go       = accept
                  || ((state == ST_FIRST) && s_vld)
                  || (pair_end && (verdict == VD_RETRY || verdict == VD_CONFIRM));

  tpc_reader #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TOG_BIT(TOG_BIT),
    .ERR_BIT(ERR_BIT)
  ) u_reader (
    .clk      (clk),
    .rst      (rst),
    .go_i     (go),
    .addr_i   (go_addr),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .rd_data_i(rd_data_i),
    .tog_o    (s_tog),
    .err_o    (s_err),
    .vld_o    (s_vld)
  );

  tpc_judge u_judge (
    .tog_a_i     (tog_a_q),
    .tog_b_i     (s_tog),
    .err_b_i     (s_err),
    .confirm_i   (confirm_q),
    .limit_last_i(limit_last),
    .verdict_o   (verdict)
  );

  tpc_pair_limit #(
    .MAX_PAIRS(MAX_PAIRS),
    .LIMIT_EN (LIMIT_EN)
  ) u_limit (
    .clk    (clk),
    .rst    (rst),
    .clear_i(accept),
    .bump_i (bump),
    .last_o (limit_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      confirm_q <= 1'b0;
      tog_a_q   <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            addr_q    <= addr_i;
            confirm_q <= 1'b0;
            state     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (s_vld) begin
            tog_a_q <= s_tog;
            state   <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (s_vld) begin
            case (verdict)
              VD_PASS: begin
                done_o <= 1'b1;
                pass_o <= 1'b1;
                state  <= ST_IDLE;
              end
              VD_FAIL: begin
                done_o <= 1'b1;
                fail_o <= 1'b1;
                state  <= ST_IDLE;
              end
              VD_CONFIRM: begin
                confirm_q <= 1'b1;
                state     <= ST_FIRST;
              end
              default: state <= ST_FIRST;
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Completion carries exactly one verdict.
  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pass_o ^ fail_o));

  // Verdict flags never appear outside the completion pulse.
  assert_verdict_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (pass_o || fail_o) |-> done_o);

  // Completion lasts a single cycle.
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // No read is pending while idle.
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !rd_req_o);

  // Reads always target the captured address.
  assert_read_addr_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (rd_addr_o == addr_q));

  // A start while busy leaves the captured address alone.
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start_i) |=> $stable(addr_q));

  // A confirming pair can only follow a pair that saw the error bit.
  assert_confirm_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(confirm_q) |-> $past(s_err && s_vld));

endmodule

// File: tb/sim_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module sim_toggle_poll_ctrl;

  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 16;
  localparam int MAX_PAIRS = 4;
  localparam int NV        = 11;

  // Vector: [31:28] expected reads, [24] expected fail, [19:0] up to ten
  // 2-bit read codes, word k at [2k+1:2k], code = {bit6, bit5}.
  localparam logic [31:0] VEC [NV] = '{
    32'h2000000A,  // R3 steady pair
    32'h400000A8,  // R4 toggle, retry, steady
    32'h4100008C,  // R5 error seen, confirm still toggles
    32'h400000AC,  // R5 error seen, confirm steady
    32'h610002C8,  // R4 then R5 fail
    32'h81008888,  // R8 limit reached
    32'h400000A9,  // R4 error bit on first read only
    32'h2000000F,  // R3 error bit but steady
    32'hA00AC888,  // R8 limit pair has error bit -> confirm
    32'h40000002,  // R4 toggle 1->0 then steady
    32'h41000026   // R5 toggle 1->0 with error, confirm toggles
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic rd_ack_i = 1'b0;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic done_o, pass_o, fail_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [19:0] script = '0;
  int script_base = 0;
  int lat = 0;
  logic [ADDR_W-1:0] exp_addr = '0;

  int reads_total = 0;
  int addr_err = 0;
  int lat_cnt = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MAX_PAIRS(MAX_PAIRS)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .addr_i   (addr_i),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .rd_data_i(rd_data_i),
    .done_o   (done_o),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );

  function automatic logic [DATA_W-1:0] mkword(input int idx);
    logic [1:0] code;
    logic [DATA_W-1:0] w;
    code = (idx >= 0 && idx < 10) ? script[2*idx +: 2] : 2'b00;
    w = (16'hA51F ^ DATA_W'(idx * 16'h0301)) & ~16'h0060;
    w[6] = code[1];
    w[5] = code[0];
    return w;
  endfunction

  // Memory-side responder: acknowledges after lat idle cycles.
  always @(negedge clk) begin
    if (rd_ack_i) begin
      rd_ack_i = 1'b0;
      reads_total = reads_total + 1;
      lat_cnt = 0;
    end else if (rd_req_o && !rst) begin
      if (rd_addr_o != exp_addr) addr_err = addr_err + 1;
      if (lat_cnt >= lat) begin
        rd_ack_i  = 1'b1;
        rd_data_i = mkword(reads_total - script_base);
      end else begin
        lat_cnt = lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic launch(input logic [ADDR_W-1:0] a);
    exp_addr = a;
    addr_i   = a;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic wait_done(output logic f, output logic p, output logic ok);
    ok = 1'b0; f = 1'b0; p = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done_o) begin
        f = fail_o; p = pass_o; ok = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    logic f, p, ok;
    int r0;

    repeat (3) @(negedge clk);
    check(!done_o && !pass_o && !fail_o && !rd_req_o, "R1 reset outputs",
          {done_o, pass_o, fail_o, rd_req_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      script      = VEC[i][19:0];
      script_base = reads_total;
      lat         = i % 3;
      r0          = reads_total;
      launch(ADDR_W'(24'h010000 + i * 24'h000123));
      wait_done(f, p, ok);
      check(ok, "R6 completion seen", ok, 1);
      check(ok && (f == VEC[i][24]) && (p == !VEC[i][24]),
            $sformatf("R3 R4 R5 R8 verdict fail-flag vec %0d", i), f, VEC[i][24]);
      check(ok && (f ^ p), "R6 one verdict", {f, p}, 1);
      check(reads_total - r0 == int'(VEC[i][31:28]),
            $sformatf("R2 read count vec %0d", i), reads_total - r0, VEC[i][31:28]);
      @(negedge clk);
      check(!done_o && !pass_o && !fail_o, "R6 pulse ends", {done_o, pass_o, fail_o}, 0);
    end
    check(addr_err == 0, "R2 read address", addr_err, 0);

    // R7: start while busy is ignored
    script = 20'h000A8; script_base = reads_total; lat = 5; r0 = reads_total;
    launch(24'h0A0A0A);
    repeat (3) @(negedge clk);
    addr_i = 24'h555555; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(f, p, ok);
    check(ok && p && !f, "R7 busy start verdict", {f, p}, 1);
    check(reads_total - r0 == 4, "R7 busy start read count", reads_total - r0, 4);
    check(addr_err == 0, "R7 busy start address", addr_err, 0);
    repeat (10) @(negedge clk);
    check(reads_total - r0 == 4 && !rd_req_o, "R6 idle after done",
          reads_total - r0, 4);

    // R9: start in the done cycle
    script = 20'h00A8A; script_base = reads_total; lat = 1; r0 = reads_total;
    launch(24'h123456);
    wait_done(f, p, ok);
    check(ok && p && !f, "R9 first op verdict", {f, p}, 1);
    check(reads_total - r0 == 2, "R9 first op reads", reads_total - r0, 2);
    launch(24'h654321);
    check(!done_o, "R9 no second done", done_o, 0);
    wait_done(f, p, ok);
    check(ok && p && !f, "R9 second op verdict", {f, p}, 1);
    check(reads_total - r0 == 6, "R9 second op reads", reads_total - r0, 6);
    check(addr_err == 0, "R9 second op address", addr_err, 0);

    // R1: reset in the middle of an operation
    script = 20'h88888; script_base = reads_total; lat = 4;
    launch(24'h00BEEF);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!rd_req_o && !done_o && !pass_o && !fail_o, "R1 mid-op reset",
          {rd_req_o, done_o, pass_o, fail_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!rd_req_o && !done_o, "R1 idle after reset", {rd_req_o, done_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule